// File: doc/BRIEF.md
# In-Order Pipeline Interlock Controller

This block is the hazard interlock for a five-stage in-order integer pipeline that has no forwarding paths. Each instruction word held in the decode register is classified by its major opcode. The classification gives the register the instruction will write, whether that write really happens, and which of its two source registers it reads. The destination and its write flag then travel down the execute, memory and writeback stage registers. The datapath itself (register file, ALU, memories) lies outside the block. It is represented only by the stream of instruction words presented at the input.

In every cycle, the sources read by the instruction in decode are compared against the pending writes in all three downstream stages. On any match the block asserts `stall`. While `stall` is high, the fetch side must keep presenting the same word, because it is not accepted. The decode register keeps its contents, and an empty slot with no write is pushed into execute. The register file is taken not to pass a same-cycle write through to a read, so the writeback stage is part of the comparison. A consumer placed directly behind its producer therefore waits three cycles.

Top module: `ilk_ctrl`

## Requirements
- R1: Source and destination register numbers always come from the same bit positions of the word: destination bits [11:7], first source bits [19:15], second source bits [24:20]. Opcode bits [6:0] are decoded with these values: 0110011 register ALU, 0010011 immediate ALU, 0000011 load, 0100011 store, 1100011 branch, 0110111 LUI, 0010111 AUIPC, 1101111 JAL, 1100111 JALR.
- R2: For register ALU, immediate ALU, load and LUI, the write flag is set only when the destination is nonzero. For AUIPC, JAL and JALR it is always set, including a destination of x0. For every other opcode it is clear.
- R3: The first source is read by register ALU, immediate ALU, load, store, branch and JALR. The second source is read only by register ALU, store and branch.
- R4: `stall` is high exactly when decode holds a valid instruction and at least one of its read sources equals the destination of an execute, memory or writeback entry whose write flag is set.
- R5: While `stall` is high, the input word is not taken and `dec_instr` keeps its value into the next cycle.
- R6: In the cycle after a stall, the execute stage holds an empty entry, with `ex_valid` and `ex_wen` both low.
- R7: An instruction leaving decode appears in execute one cycle later, with its destination and write flag. Those fields move to memory and then to writeback one cycle per stage.
- R8: A consumer issued directly after its producer stalls for 3 cycles. With g independent instructions between them, it stalls for max(0, 3-g) cycles. An instruction with no dependency never stalls.
- R9: A synchronous active-high reset clears the decode valid bit and the valid and write flags of all three downstream stages, so `stall` is low after reset.
- R10: A word with any other opcode neither writes nor reads. It causes no stall and suffers none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetched word is presented |
| in_instr | input | 32 | Fetched instruction word |
| stall | output | 1 | Interlock active; input not taken this cycle |
| dec_valid | output | 1 | Decode register holds an instruction |
| dec_instr | output | 32 | Instruction word held in decode |
| ex_valid | output | 1 | Execute entry valid |
| ex_wen | output | 1 | Execute entry will write a register |
| ex_dst | output | 5 | Execute entry destination |
| mem_valid | output | 1 | Memory entry valid |
| mem_wen | output | 1 | Memory entry will write a register |
| mem_dst | output | 5 | Memory entry destination |
| wb_valid | output | 1 | Writeback entry valid |
| wb_wen | output | 1 | Writeback entry will write a register |
| wb_dst | output | 5 | Writeback entry destination |

## Verification
The bench sweeps every pairing of producer class and consumer class, with the shared register placed on the first source, on the second source, or on neither. A wrong read-enable or write-flag entry would show up as a stall count of 3 where 0 is expected, or the reverse. The bench varies the gap between producer and consumer from zero to four. A design that left out the writeback comparison, or that let a bubble carry a write, would report 2 or more than 3 stall cycles instead of max(0, 3-g). Writes to x0 are checked in two forms: the ALU form must not stall a reader of x0, while the AUIPC form must. The bench also checks that a stalled decode word holds still and that execute empties behind it.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;

  localparam logic [6:0] OPC_ALU   = 7'b0110011;
  localparam logic [6:0] OPC_ALUI  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;

  // one downstream stage entry
  typedef struct packed {
    logic           v;
    logic           wen;
    logic [RAW-1:0] dst;
  } stg_t;
endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
  import ilk_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output logic [RAW-1:0]  dst,
  output logic [RAW-1:0]  src1,
  output logic [RAW-1:0]  src2,
  output logic            wen,
  output logic            rd_en1,
  output logic            rd_en2
);
  logic nz;

  always_comb begin
    dst    = instr[11:7];
    src1   = instr[19:15];
    src2   = instr[24:20];
    nz     = (instr[11:7] != '0);
    wen    = 1'b0;
    rd_en1 = 1'b0;
    rd_en2 = 1'b0;
    case (instr[6:0])
      OPC_ALU: begin
        wen = nz; rd_en1 = 1'b1; rd_en2 = 1'b1;
      end
      OPC_ALUI, OPC_LOAD: begin
        wen = nz; rd_en1 = 1'b1;
      end
      OPC_LUI:             wen = nz;
      OPC_AUIPC, OPC_JAL:  wen = 1'b1;
      OPC_JALR: begin
        wen = 1'b1; rd_en1 = 1'b1;
      end
      OPC_STORE, OPC_BR: begin
        rd_en1 = 1'b1; rd_en2 = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ilk_match.sv
module ilk_match
  import ilk_pkg::*;
#(
  parameter int NSTG = 3
)(
  input  stg_t [NSTG-1:0] stg,
  input  logic            dvalid,
  input  logic [RAW-1:0]  src1,
  input  logic [RAW-1:0]  src2,
  input  logic            rd_en1,
  input  logic            rd_en2,
  output logic            stall
);
  logic [NSTG-1:0] hit1, hit2;

  for (genvar i = 0; i < NSTG; i++) begin : g_cmp
    assign hit1[i] = stg[i].wen && (stg[i].dst == src1);
    assign hit2[i] = stg[i].wen && (stg[i].dst == src2);
  end

  assign stall = dvalid && ((rd_en1 && (|hit1)) || (rd_en2 && (|hit2)));
endmodule

// File: rtl/ilk_stages.sv
module ilk_stages
  import ilk_pkg::*;
#(
  parameter int NSTG = 3
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            bubble,
  input  stg_t            from_dec,
  output stg_t [NSTG-1:0] stg
);
  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[i] <= '0;
      end else if (i == 0) begin
        stg[i] <= bubble ? stg_t'('0) : from_dec;
      end else begin
        stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  end
endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int CMP_STAGES = 3
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  output logic            stall,
  output logic            dec_valid,
  output logic [31:0]     dec_instr,
  output logic            ex_valid,
  output logic            ex_wen,
  output logic [4:0]      ex_dst,
  output logic            mem_valid,
  output logic            mem_wen,
  output logic [4:0]      mem_dst,
  output logic            wb_valid,
  output logic            wb_wen,
  output logic [4:0]      wb_dst
);
  localparam int EXI = 0;
  localparam int MAI = 1;
  localparam int WBI = CMP_STAGES - 1;

  logic [RAW-1:0] d_dst, d_src1, d_src2;
  logic           d_wen, d_re1, d_re2;
  stg_t           d_info;
  stg_t [CMP_STAGES-1:0] stg;

  // decode register: held while interlocked
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_instr <= '0;
    end else if (!stall) begin
      dec_valid <= in_valid;
      dec_instr <= in_instr;
    end
  end

  ilk_decode dec_u (
    .instr  (dec_instr),
    .dst    (d_dst),
    .src1   (d_src1),
    .src2   (d_src2),
    .wen    (d_wen),
    .rd_en1 (d_re1),
    .rd_en2 (d_re2)
  );

  assign d_info.v   = dec_valid;
  assign d_info.wen = dec_valid && d_wen;
  assign d_info.dst = d_dst;

  ilk_match #(.NSTG(CMP_STAGES)) cmp_u (
    .stg    (stg),
    .dvalid (dec_valid),
    .src1   (d_src1),
    .src2   (d_src2),
    .rd_en1 (d_re1),
    .rd_en2 (d_re2),
    .stall  (stall)
  );

  ilk_stages #(.NSTG(CMP_STAGES)) pipe_u (
    .clk      (clk),
    .rst      (rst),
    .bubble   (stall),
    .from_dec (d_info),
    .stg      (stg)
  );

  assign ex_valid  = stg[EXI].v;
  assign ex_wen    = stg[EXI].wen;
  assign ex_dst    = stg[EXI].dst;
  assign mem_valid = stg[MAI].v;
  assign mem_wen   = stg[MAI].wen;
  assign mem_dst   = stg[MAI].dst;
  assign wb_valid  = stg[WBI].v;
  assign wb_wen    = stg[WBI].wen;
  assign wb_dst    = stg[WBI].dst;
endmodule

// File: rtl/ilk_ctrl_chk.sv
module ilk_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic        dec_valid,
  input logic [31:0] dec_instr,
  input logic        ex_valid,
  input logic        ex_wen,
  input logic [4:0]  ex_dst,
  input logic        mem_valid,
  input logic        mem_wen,
  input logic [4:0]  mem_dst,
  input logic        wb_valid,
  input logic        wb_wen,
  input logic [4:0]  wb_dst
);
  // R4: only a valid decode entry can interlock
  a_r4_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
    stall |-> dec_valid);

  // R5: decode word frozen across a stall
  a_r5_hold_decode: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(dec_instr));

  // R6: empty slot enters execute behind a stall
  a_r6_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_valid && !ex_wen));

  // R7: execute moves to memory, memory to writeback
  a_r7_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_valid == $past(ex_valid) && mem_wen == $past(ex_wen) &&
              mem_dst == $past(ex_dst) && wb_valid == $past(mem_valid) &&
              wb_wen == $past(mem_wen) && wb_dst == $past(mem_dst)));

  // R9: reset empties every stage
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!dec_valid && !ex_valid && !ex_wen && !mem_valid && !mem_wen &&
             !wb_valid && !wb_wen));
endmodule

bind ilk_ctrl ilk_ctrl_chk chk_i (.*);

// File: tb/ilk_ctrl_tb_top.sv
module ilk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_instr;
  logic        stall, dec_valid;
  logic [31:0] dec_instr;
  logic        ex_valid, ex_wen, mem_valid, mem_wen, wb_valid, wb_wen;
  logic [4:0]  ex_dst, mem_dst, wb_dst;

  int checks = 0;
  int fails  = 0;
  int stall_cnt = 0;
  bit done = 1'b0;

  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [6:0] OPS [10] = '{7'b0110011, 7'b0010011, 7'b0000011,
    7'b0100011, 7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111,
    7'b0001111};

  always #2 clk = ~clk;

  ilk_ctrl dut_i (.*);

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] rd,
                                     input logic [4:0] s1, input logic [4:0] s2);
    return {7'd0, s2, s1, 3'd0, rd, op};
  endfunction

  // R2 write flag per opcode class, from the requirement
  function automatic bit exp_wen(input int k, input logic [4:0] rd);
    if (k <= 2 || k == 5) return rd != 0;
    if (k >= 6 && k <= 8) return 1'b1;
    return 1'b0;
  endfunction
  // R3 read enables per class
  function automatic bit exp_re1(input int k);
    return (k <= 4) || (k == 8);
  endfunction
  function automatic bit exp_re2(input int k);
    return (k == 0) || (k == 3) || (k == 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // present a word; wait out stalls, checking hold and bubble
  task automatic push(input logic [31:0] w);
    logic [31:0] held;
    in_instr = w;
    in_valid = 1'b1;
    while (stall) begin
      stall_cnt++;
      held = dec_instr;
      @(negedge clk);
      chk(dec_instr == held, "R5 decode hold", int'(dec_instr), int'(held));
      chk(!ex_valid && !ex_wen, "R6 bubble", int'({ex_valid, ex_wen}), 0);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) push(NOP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_instr = NOP;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!stall && !dec_valid && !ex_valid && !mem_valid && !wb_valid &&
        !ex_wen && !mem_wen && !wb_wen, "R9 reset state",
        int'({stall, dec_valid, ex_valid, mem_valid, wb_valid}), 0);
    rst = 1'b0;
    drain();

    // R1 R2 R3 R4 R8 R10: class pair sweep
    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 10; c++) begin
        for (int m = 0; m < 3; m++) begin
          logic [31:0] pw, cw;
          int exp_s;
          pw = mk(OPS[p], 5'd5, 5'd0, 5'd0);
          cw = mk(OPS[c], 5'd6, (m == 0) ? 5'd5 : 5'd7, (m == 1) ? 5'd5 : 5'd9);
          exp_s = (exp_wen(p, 5'd5) && ((exp_re1(c) && m == 0) ||
                   (exp_re2(c) && m == 1))) ? 3 : 0;
          stall_cnt = 0;
          push(pw);
          push(cw);
          // R7: producer now in execute
          chk(ex_valid && ex_wen == exp_wen(p, 5'd5) && ex_dst == 5'd5,
              "R7 execute entry", int'({ex_valid, ex_wen, ex_dst}),
              int'({1'b1, exp_wen(p, 5'd5), 5'd5}));
          drain();
          chk(stall_cnt == exp_s, "R4 R8 R10 pair stalls", stall_cnt, exp_s);
        end
      end
    end

    // R8: distance sweep
    for (int g = 0; g < 5; g++) begin
      int e;
      e = (g >= 3) ? 0 : 3 - g;
      stall_cnt = 0;
      push(mk(OPS[0], 5'd12, 5'd1, 5'd2));
      for (int k = 0; k < g; k++) push(NOP);
      push(mk(OPS[0], 5'd13, 5'd3, 5'd12));
      drain();
      chk(stall_cnt == e, "R8 gap stalls", stall_cnt, e);
    end

    // R7: destination reaches writeback two cycles after execute
    push(mk(OPS[2], 5'd21, 5'd0, 5'd0));
    push(NOP);
    push(NOP);
    push(NOP);
    chk(wb_valid && wb_wen && wb_dst == 5'd21, "R7 writeback entry",
        int'({wb_valid, wb_wen, wb_dst}), int'({2'b11, 5'd21}));
    drain();

    // R2: ALU write to x0 is suppressed
    stall_cnt = 0;
    push(mk(OPS[0], 5'd0, 5'd1, 5'd2));
    push(mk(OPS[0], 5'd4, 5'd0, 5'd0));
    drain();
    chk(stall_cnt == 0, "R2 x0 alu no stall", stall_cnt, 0);

    // R2: AUIPC write to x0 still interlocks a reader of x0
    stall_cnt = 0;
    push(mk(OPS[6], 5'd0, 5'd0, 5'd0));
    push(mk(OPS[0], 5'd4, 5'd0, 5'd0));
    drain();
    chk(stall_cnt == 3, "R2 x0 auipc stall", stall_cnt, 3);

    // R9: reset mid-flight clears pipeline
    push(mk(OPS[0], 5'd8, 5'd1, 5'd2));
    push(mk(OPS[0], 5'd9, 5'd8, 5'd8));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!stall && !dec_valid && !ex_valid && !ex_wen, "R9 reset mid-run",
        int'({stall, dec_valid, ex_valid, ex_wen}), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule